// File: doc/BRIEF.md
# Speculative Load Alias Tracker

This block keeps a record of loads that were moved ahead of stores whose addresses could not be proven distinct. When such a load executes, it writes an entry into a small fully associative table. The entry holds the load's destination register tag, its start address and its access size. Every store that follows is compared at once against all live entries, and any entry whose byte range shares at least one byte with the store is dropped.

Before the loaded value is consumed, the pipeline sends a check with the register tag. One cycle later the block answers pass or fail. A fail means the load may have read stale data, so the caller must run its recovery sequence. That sequence repeats the load, which allocates the entry again. A flush input empties the table in one cycle.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset every entry is empty, and any check answers fail.
- R2: A check presented in cycle N produces `chk_resp_valid_o` high in cycle N+1, with `chk_pass_o` reporting the result. An allocation in cycle N is visible to checks from cycle N+1 on.
- R3: A check for a tag that has no live entry answers fail.
- R4: The size code c of an allocation or a store covers bytes [addr, addr+c] (c+1 bytes). A store invalidates an entry when the two ranges share a byte, including partial overlap at either end. A store that is only adjacent leaves the entry alive.
- R5: One store invalidates every overlapping entry in the same cycle.
- R6: Allocating a tag that already has a live entry overwrites that entry in place. A tag never occupies two entries. A later store that overlaps only the old range leaves the new entry alive.
- R7: Slot choice uses the table as it stood before that cycle's store, in this order: first the same-tag entry, then the lowest-index empty entry. When the table is full, the slot is chosen by a rotating pointer. The pointer starts at index 0 after reset and advances by one on each eviction. An evicted tag then fails its check.
- R8: When a store and a check arrive in the same cycle, the store applies first, so the check fails if the store hit that tag's entry.
- R9: Flush empties all entries in one cycle. An allocation in the flush cycle is dropped, and a check in the flush cycle answers fail.
- R10: A check in the same cycle as an allocation of its tag sees the table before that allocation. A store in the same cycle as an allocation does not invalidate the newly written entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the whole table |
| alloc_valid_i | input | 1 | Speculative load records an entry |
| alloc_tag_i | input | TAG_W | Destination register tag of the load |
| alloc_addr_i | input | ADDR_W | Start byte address of the load |
| alloc_size_i | input | SIZE_W | Load size code (bytes minus one) |
| st_valid_i | input | 1 | Store snoop valid |
| st_addr_i | input | ADDR_W | Start byte address of the store |
| st_size_i | input | SIZE_W | Store size code (bytes minus one) |
| chk_valid_i | input | 1 | Survival check request |
| chk_tag_i | input | TAG_W | Register tag being checked |
| chk_resp_valid_o | output | 1 | Check answer valid, one cycle after the request |
| chk_pass_o | output | 1 | 1 means the entry survived, 0 means recovery is needed |

## Verification
Directed store patterns sit exactly adjacent to an entry, overlap it by a single byte at its low or high end, or cover several entries at once. Together they separate a correct range comparison from off-by-one or start-address-only matching. The full-table sequence tells round-robin eviction apart from reuse of a freed slot and from same-tag replacement. Same-cycle mixes of store, check, allocation and flush pin down the ordering rules. A long pseudo-random phase over a few tags and a narrow address window then stresses collisions against an independent table model.

// File: rtl/spec_load_tracker.sv
module spec_load_tracker #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 7,
  parameter int ADDR_W  = 64,
  parameter int SIZE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              alloc_valid_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [SIZE_W-1:0] alloc_size_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [SIZE_W-1:0] st_size_i,
  input  logic              chk_valid_i,
  input  logic [TAG_W-1:0]  chk_tag_i,
  output logic              chk_resp_valid_o,
  output logic              chk_pass_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int EXT_W = ADDR_W + 1 - SIZE_W;
  localparam logic [ADDR_W:0] ONE = {{ADDR_W{1'b0}}, 1'b1};
  localparam logic [ENTRIES-1:0] BIT0 = {{(ENTRIES-1){1'b0}}, 1'b1};
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [SIZE_W-1:0]  size_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] st_hit, chk_match, alloc_match, alloc_vec;
  logic [IDX_W-1:0]   match_idx, free_idx, slot;
  logic               full, evict;

  logic [ADDR_W:0] st_lo, st_end;
  assign st_lo  = {1'b0, st_addr_i};
  assign st_end = st_lo + {{EXT_W{1'b0}}, st_size_i} + ONE;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [ADDR_W:0] e_lo, e_end;
    assign e_lo  = {1'b0, addr_q[g]};
    assign e_end = e_lo + {{EXT_W{1'b0}}, size_q[g]} + ONE;
    assign st_hit[g]      = st_valid_i && valid_q[g] && (e_lo < st_end) && (st_lo < e_end);
    assign chk_match[g]   = valid_q[g] && (tag_q[g] == chk_tag_i);
    assign alloc_match[g] = valid_q[g] && (tag_q[g] == alloc_tag_i);
  end

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (alloc_match[i]) match_idx = IDX_W'(i);
      if (!valid_q[i])    free_idx  = IDX_W'(i);
    end
  end

  assign full      = &valid_q;
  assign evict     = alloc_valid_i && !flush_i && (alloc_match == '0) && full;
  assign slot      = (|alloc_match) ? match_idx : (full ? rr_q : free_idx);
  assign alloc_vec = alloc_valid_i ? (BIT0 << slot) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q          <= '0;
      rr_q             <= '0;
      chk_resp_valid_o <= 1'b0;
      chk_pass_o       <= 1'b0;
    end else begin
      chk_resp_valid_o <= chk_valid_i;
      chk_pass_o       <= chk_valid_i && !flush_i && |(chk_match & ~st_hit);
      if (flush_i) valid_q <= '0;
      else         valid_q <= (valid_q & ~st_hit) | alloc_vec;
      if (evict) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_valid_i && !flush_i) begin
      tag_q[slot]  <= alloc_tag_i;
      addr_q[slot] <= alloc_addr_i;
      size_q[slot] <= alloc_size_i;
    end
  end

  assert_resp_follows_chk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |=> chk_resp_valid_o);
  assert_idle_no_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid_i |=> !chk_resp_valid_o);
  assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |-> $onehot0(chk_match));
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));
  assert_flush_check_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && chk_valid_i) |=> !chk_pass_o);
  assert_no_silent_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_valid_i && !flush_i) |=> ($countones(valid_q) >= $past($countones(valid_q))));
  assert_store_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && ((chk_match & ~st_hit) == '0)) |=> !chk_pass_o);
endmodule

// File: tb/spec_load_tracker_tb.sv
module spec_load_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 0, rst_n = 0;
  logic flush_i = 0, alloc_valid_i = 0, st_valid_i = 0, chk_valid_i = 0;
  logic [6:0] alloc_tag_i = 0, chk_tag_i = 0;
  logic [63:0] alloc_addr_i = 0, st_addr_i = 0;
  logic [3:0] alloc_size_i = 0, st_size_i = 0;
  logic chk_resp_valid_o, chk_pass_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_load_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .alloc_valid_i(alloc_valid_i), .alloc_tag_i(alloc_tag_i),
    .alloc_addr_i(alloc_addr_i), .alloc_size_i(alloc_size_i),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
    .chk_valid_i(chk_valid_i), .chk_tag_i(chk_tag_i),
    .chk_resp_valid_o(chk_resp_valid_o), .chk_pass_o(chk_pass_o));

  int n_cmp = 0, n_bad = 0;
  bit    exp_q[$];
  string req_q[$];

  bit          m_v [N];
  logic [6:0]  m_t [N];
  logic [63:0] m_a [N];
  logic [3:0]  m_s [N];
  int          m_ptr = 0;

  function automatic bit overlap(logic [63:0] a, logic [3:0] as, logic [63:0] b, logic [3:0] bs);
    logic [64:0] a_hi, b_hi;
    a_hi = {1'b0, a} + as;
    b_hi = {1'b0, b} + bs;
    return ({1'b0, a} <= b_hi) && ({1'b0, b} <= a_hi);
  endfunction

  task automatic compare(bit act, bit exp, string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step(bit fl, bit av, int atag, logic [63:0] aaddr, int asz,
                      bit sv, logic [63:0] saddr, int ssz, bit cv, int ctag, string req);
    int slot;
    bit e;
    @(negedge clk);
    flush_i = fl;
    alloc_valid_i = av; alloc_tag_i = 7'(atag); alloc_addr_i = aaddr; alloc_size_i = 4'(asz);
    st_valid_i = sv; st_addr_i = saddr; st_size_i = 4'(ssz);
    chk_valid_i = cv; chk_tag_i = 7'(ctag);
    if (cv) begin
      e = 0;
      if (!fl)
        for (int i = 0; i < N; i++)
          if (m_v[i] && m_t[i] == 7'(ctag) && !(sv && overlap(m_a[i], m_s[i], saddr, 4'(ssz)))) e = 1;
      exp_q.push_back(e);
      req_q.push_back(req);
    end
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      slot = -1;
      if (av) begin
        for (int i = 0; i < N; i++) if (slot < 0 && m_v[i] && m_t[i] == 7'(atag)) slot = i;
        for (int i = 0; i < N; i++) if (slot < 0 && !m_v[i]) slot = i;
        if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % N; end
      end
      if (sv)
        for (int i = 0; i < N; i++)
          if (m_v[i] && overlap(m_a[i], m_s[i], saddr, 4'(ssz))) m_v[i] = 0;
      if (av) begin
        m_v[slot] = 1; m_t[slot] = 7'(atag); m_a[slot] = aaddr; m_s[slot] = 4'(asz);
      end
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic alloc(int tag, logic [63:0] a, int sz);
    step(0, 1, tag, a, sz, 0, 0, 0, 0, 0, "");
  endtask
  task automatic store(logic [63:0] a, int sz);
    step(0, 0, 0, 0, 0, 1, a, sz, 0, 0, "");
  endtask
  task automatic check(int tag, string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, tag, req);
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_resp_valid_o) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2: actual unexpected response expected none");
      end else begin
        bit e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        compare(chk_pass_o, e, r);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    compare(chk_resp_valid_o, 0, "R1 reset resp_valid");
    compare(chk_pass_o, 0, "R1 reset pass");
    rst_n = 1;
    check(5, "R1 empty after reset");

    alloc(5, 64'h100, 7);
    check(5, "R2 pass after alloc");
    check(6, "R3 unknown tag");
    store(64'h108, 3);
    check(5, "R4 adjacent high store");
    store(64'h0F8, 7);
    check(5, "R4 adjacent low store");
    store(64'h107, 0);
    check(5, "R4 one byte high-end overlap");
    alloc(5, 64'h100, 7);
    store(64'h0FC, 4);
    check(5, "R4 one byte low-end overlap");

    alloc(10, 64'h200, 3);
    alloc(11, 64'h204, 3);
    alloc(12, 64'h300, 3);
    store(64'h202, 3);
    check(10, "R5 multi invalidate a");
    check(11, "R5 multi invalidate b");
    check(12, "R5 untouched entry");

    alloc(12, 64'h400, 1);
    store(64'h300, 3);
    check(12, "R6 realloc moved range");
    store(64'h401, 0);
    check(12, "R6 new range hit");

    alloc(20, 64'h500, 3);
    step(0, 0, 0, 0, 0, 1, 64'h503, 0, 1, 20, "R8 store and check same cycle");
    step(0, 1, 21, 64'h600, 3, 0, 0, 0, 1, 21, "R10 check sees pre-alloc table");
    check(21, "R10 alloc visible next cycle");
    step(0, 1, 22, 64'h700, 3, 1, 64'h700, 3, 0, 0, "");
    check(22, "R10 same-cycle store spares new entry");

    step(1, 1, 23, 64'h800, 0, 0, 0, 0, 1, 22, "R9 check in flush cycle");
    check(22, "R9 flushed entry");
    check(23, "R9 alloc in flush cycle dropped");

    for (int t = 0; t < N; t++) alloc(t, 64'h1000 + 64'(t) * 16, 7);
    check(0, "R7 full table tag0");
    check(31, "R7 full table tag31");
    alloc(40, 64'h3000, 3);
    check(0, "R7 first eviction takes slot 0");
    check(40, "R7 evicting alloc lives");
    alloc(41, 64'h3010, 3);
    check(1, "R7 pointer advanced to slot 1");
    check(2, "R7 slot 2 kept");
    store(64'h1050, 0);
    alloc(42, 64'h3020, 3);
    check(2, "R7 freed slot reused not evicted");
    check(42, "R7 alloc into freed slot");
    alloc(43, 64'h3030, 3);
    check(2, "R7 pointer resumes at slot 2");
    for (int t = 0; t < 44; t++) check(t, "R7 table sweep");

    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    for (int k = 0; k < 3000; k++) begin
      bit fl, av, sv, cv;
      fl = ($urandom_range(0, 99) == 0);
      av = ($urandom_range(0, 2) == 0);
      sv = ($urandom_range(0, 2) == 0);
      cv = ($urandom_range(0, 1) == 0);
      step(fl, av, $urandom_range(0, 39), 64'h4000 + 64'($urandom_range(0, 95)), $urandom_range(0, 7),
           sv, 64'h4000 + 64'($urandom_range(0, 95)), $urandom_range(0, 7),
           cv, $urandom_range(0, 39), "R4 R6 R7 R8 mixed traffic");
    end
    idle(); idle(); idle();
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule